// File: doc/BRIEF.md
# CAN FD Transmit Format Selector

This block sits beside a CAN controller's transmit path. For each frame pulled from the transmit queue, it decides how the frame is coded on the bus. It combines two global configuration enables with two per-element flags. From these it derives three values: whether the frame uses the FD format, whether it switches bit rate, and the level of the error-state indicator bit. The indicator bit is taken from the transmitter's error-passive status at the moment the frame starts.

During the frame, the block drives a timing-select output that tells the bit timing engine which parameter set to use. The nominal set covers arbitration. The data set is used after a switching BRS bit. The select falls back to nominal at the CRC delimiter or at the first detected error, whichever comes first. The two global enables are write-protected. They accept new values only while both the init and the configuration-change-enable status inputs are high.

Top module: `canfd_txfmt_sel`

## Requirements
- R1: After synchronous reset, cfg_fd_en, cfg_brs_en, tx_fdf, tx_brs, tx_esi and tsel_data are all 0 (with the default reset parameters).
- R2: A write on cfg_we updates cfg_fd_en/cfg_brs_en on the next cycle only when cfg_init and cfg_cce are both 1. Any other write leaves both enables unchanged.
- R3: With cfg_fd_en = 0, a frame started by sof_stb has tx_fdf = 0 and tx_brs = 0, whatever the element flags and cfg_brs_en.
- R4: With cfg_fd_en = 1 and cfg_brs_en = 0, tx_fdf follows elem_fdf and tx_brs is 0.
- R5: With both enables at 1, tx_fdf = elem_fdf and tx_brs = elem_fdf AND elem_brs (tx_brs = 1 means a recessive, switching BRS bit).
- R6: An element with elem_fdf = 0 is always sent Classic (tx_fdf = 0, tx_brs = 0) under every configuration.
- R7: tx_fdf and tx_brs are captured on the cycle after sof_stb and then stay unchanged until the next sof_stb, even if the enables or element flags change.
- R8: tx_esi equals err_passive as sampled on the sof_stb cycle (1 = recessive, error passive) and holds for the whole frame.
- R9: tsel_data (0 = nominal set, 1 = data set) is 0 on the cycle after sof_stb. A brs_smp_stb inside a frame whose tx_brs = 1 sets it to 1 on the next cycle.
- R10: crc_dlm_stb or err_stb returns tsel_data to 0 on the next cycle and ends the frame. A later brs_smp_stb before the next sof_stb leaves it at 0.
- R11: In a frame with tx_brs = 0, brs_smp_stb leaves tsel_data at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_init | input | 1 | Controller init status |
| cfg_cce | input | 1 | Configuration-change-enable status |
| cfg_we | input | 1 | Write strobe for the enables |
| cfg_fd_en_wr | input | 1 | FD-enable write data |
| cfg_brs_en_wr | input | 1 | Bit-rate-switch-enable write data |
| cfg_fd_en | output | 1 | Current FD-enable |
| cfg_brs_en | output | 1 | Current bit-rate-switch-enable |
| elem_fdf | input | 1 | Element requests FD format |
| elem_brs | input | 1 | Element requests bit rate switching |
| err_passive | input | 1 | Transmitter is error passive |
| sof_stb | input | 1 | Start of frame strobe |
| brs_smp_stb | input | 1 | BRS bit sample point strobe |
| crc_dlm_stb | input | 1 | CRC delimiter strobe |
| err_stb | input | 1 | Error detected strobe |
| tx_fdf | output | 1 | Effective FD format flag |
| tx_brs | output | 1 | Effective BRS value |
| tx_esi | output | 1 | ESI bit value (1 = recessive) |
| tsel_data | output | 1 | Timing set select, 1 = data |

## Verification
The bench builds the block with its default reset parameters, so both enables come out of reset cleared. This makes the Classic-only reset state observable and means the write protection must be passed before any FD frame can appear. A vector table covers all sixteen combinations of enables and element flags, with the error-passive input toggled across them. Directed frames then drive the timing select through switch, return at the delimiter, return on error and attempted re-entry.

// File: rtl/canfd_txfmt_pkg.sv
package canfd_txfmt_pkg;

    typedef enum logic {
        TS_NOMINAL = 1'b0,
        TS_DATA    = 1'b1
    } tsel_e;

    typedef struct packed {
        logic fdf;
        logic brs;
        logic esi;
    } txfmt_t;

    localparam txfmt_t FMT_CLASSIC = '{fdf: 1'b0, brs: 1'b0, esi: 1'b0};

    function automatic txfmt_t pick_format(
        input logic fd_en,
        input logic brs_en,
        input logic efdf,
        input logic ebrs,
        input logic epas
    );
        txfmt_t f;
        f.fdf = fd_en & efdf;
        f.brs = fd_en & brs_en & efdf & ebrs;
        f.esi = epas;
        return f;
    endfunction

endpackage

// File: rtl/canfd_cfg_guard.sv
module canfd_cfg_guard #(
    parameter logic RST_FD_EN  = 1'b0,
    parameter logic RST_BRS_EN = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic init_i,
    input  logic cce_i,
    input  logic we_i,
    input  logic fd_en_wr_i,
    input  logic brs_en_wr_i,
    output logic fd_en_o,
    output logic brs_en_o
);
    logic unlocked;
    assign unlocked = init_i & cce_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            fd_en_o  <= RST_FD_EN;
            brs_en_o <= RST_BRS_EN;
        end else if (we_i && unlocked) begin
            fd_en_o  <= fd_en_wr_i;
            brs_en_o <= brs_en_wr_i;
        end
    end

    // R2: locked writes leave the enables untouched
    p_locked_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(init_i && cce_i) |=> ($stable(fd_en_o) && $stable(brs_en_o)));

    p_no_write_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> ($stable(fd_en_o) && $stable(brs_en_o)));
endmodule

// File: rtl/canfd_fmt_latch.sv
module canfd_fmt_latch
    import canfd_txfmt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sof_i,
    input  logic   fd_en_i,
    input  logic   brs_en_i,
    input  logic   efdf_i,
    input  logic   ebrs_i,
    input  logic   epas_i,
    output txfmt_t fmt_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_o <= FMT_CLASSIC;
        end else if (sof_i) begin
            fmt_o <= pick_format(fd_en_i, brs_en_i, efdf_i, ebrs_i, epas_i);
        end
    end

    // R7: format held between frame starts
    p_fmt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !sof_i |=> $stable(fmt_o));

    // R8: ESI taken from the error state at frame start
    p_esi_sample_r8: assert property (@(posedge clk) disable iff (rst)
        sof_i |=> (fmt_o.esi == $past(epas_i)));

    // R3: FD disabled gives a Classic frame
    p_fd_off_classic_r3: assert property (@(posedge clk) disable iff (rst)
        (sof_i && !fd_en_i) |=> (!fmt_o.fdf && !fmt_o.brs));

    // R6: Classic element stays Classic
    p_classic_elem_r6: assert property (@(posedge clk) disable iff (rst)
        (sof_i && !efdf_i) |=> (!fmt_o.fdf && !fmt_o.brs));

    // R4: no switching when BRS is disabled
    p_brs_off_r4: assert property (@(posedge clk) disable iff (rst)
        (sof_i && !brs_en_i) |=> !fmt_o.brs);
endmodule

// File: rtl/canfd_tsel_ctl.sv
module canfd_tsel_ctl
    import canfd_txfmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sof_i,
    input  logic  brs_smp_i,
    input  logic  crc_dlm_i,
    input  logic  err_i,
    input  logic  frame_brs_i,
    output tsel_e tsel_o
);
    logic in_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            tsel_o   <= TS_NOMINAL;
            in_frame <= 1'b0;
        end else if (sof_i) begin
            tsel_o   <= TS_NOMINAL;
            in_frame <= 1'b1;
        end else if (crc_dlm_i || err_i) begin
            tsel_o   <= TS_NOMINAL;
            in_frame <= 1'b0;
        end else if (brs_smp_i && in_frame && frame_brs_i) begin
            tsel_o   <= TS_DATA;
        end
    end

    // R9: every frame starts on the nominal set
    p_sof_nominal_r9: assert property (@(posedge clk) disable iff (rst)
        sof_i |=> (tsel_o == TS_NOMINAL));

    // R10: back to nominal at delimiter or error
    p_end_nominal_r10: assert property (@(posedge clk) disable iff (rst)
        (crc_dlm_i || err_i) |=> (tsel_o == TS_NOMINAL));

    // R11: data set only in a switching frame
    p_data_needs_brs_r11: assert property (@(posedge clk) disable iff (rst)
        (tsel_o == TS_DATA) |-> frame_brs_i);

    // R9: data set entered only at the BRS sample point
    p_data_entry_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(tsel_o) |-> $past(brs_smp_i));
endmodule

// File: rtl/canfd_txfmt_sel.sv
module canfd_txfmt_sel
    import canfd_txfmt_pkg::*;
#(
    parameter logic RST_FD_EN  = 1'b0,
    parameter logic RST_BRS_EN = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_init,
    input  logic cfg_cce,
    input  logic cfg_we,
    input  logic cfg_fd_en_wr,
    input  logic cfg_brs_en_wr,
    output logic cfg_fd_en,
    output logic cfg_brs_en,
    input  logic elem_fdf,
    input  logic elem_brs,
    input  logic err_passive,
    input  logic sof_stb,
    input  logic brs_smp_stb,
    input  logic crc_dlm_stb,
    input  logic err_stb,
    output logic tx_fdf,
    output logic tx_brs,
    output logic tx_esi,
    output logic tsel_data
);
    txfmt_t fmt_q;
    tsel_e  tsel_q;

    canfd_cfg_guard #(
        .RST_FD_EN  (RST_FD_EN),
        .RST_BRS_EN (RST_BRS_EN)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .init_i      (cfg_init),
        .cce_i       (cfg_cce),
        .we_i        (cfg_we),
        .fd_en_wr_i  (cfg_fd_en_wr),
        .brs_en_wr_i (cfg_brs_en_wr),
        .fd_en_o     (cfg_fd_en),
        .brs_en_o    (cfg_brs_en)
    );

    canfd_fmt_latch u_fmt (
        .clk      (clk),
        .rst      (rst),
        .sof_i    (sof_stb),
        .fd_en_i  (cfg_fd_en),
        .brs_en_i (cfg_brs_en),
        .efdf_i   (elem_fdf),
        .ebrs_i   (elem_brs),
        .epas_i   (err_passive),
        .fmt_o    (fmt_q)
    );

    canfd_tsel_ctl u_tsel (
        .clk         (clk),
        .rst         (rst),
        .sof_i       (sof_stb),
        .brs_smp_i   (brs_smp_stb),
        .crc_dlm_i   (crc_dlm_stb),
        .err_i       (err_stb),
        .frame_brs_i (fmt_q.brs),
        .tsel_o      (tsel_q)
    );

    assign tx_fdf    = fmt_q.fdf;
    assign tx_brs    = fmt_q.brs;
    assign tx_esi    = fmt_q.esi;
    assign tsel_data = (tsel_q == TS_DATA);

    // R5: switching only inside an FD frame
    p_brs_in_fd_r5: assert property (@(posedge clk) disable iff (rst)
        tx_brs |-> tx_fdf);
endmodule

// File: tb/canfd_txfmt_sel_tb_top.sv
module canfd_txfmt_sel_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_init = 0, cfg_cce = 0, cfg_we = 0, cfg_fd_en_wr = 0, cfg_brs_en_wr = 0;
    logic elem_fdf = 0, elem_brs = 0, err_passive = 0;
    logic sof_stb = 0, brs_smp_stb = 0, crc_dlm_stb = 0, err_stb = 0;
    logic cfg_fd_en, cfg_brs_en, tx_fdf, tx_brs, tx_esi, tsel_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    canfd_txfmt_sel dut_i (
        .clk(clk), .rst(rst),
        .cfg_init(cfg_init), .cfg_cce(cfg_cce), .cfg_we(cfg_we),
        .cfg_fd_en_wr(cfg_fd_en_wr), .cfg_brs_en_wr(cfg_brs_en_wr),
        .cfg_fd_en(cfg_fd_en), .cfg_brs_en(cfg_brs_en),
        .elem_fdf(elem_fdf), .elem_brs(elem_brs), .err_passive(err_passive),
        .sof_stb(sof_stb), .brs_smp_stb(brs_smp_stb),
        .crc_dlm_stb(crc_dlm_stb), .err_stb(err_stb),
        .tx_fdf(tx_fdf), .tx_brs(tx_brs), .tx_esi(tx_esi), .tsel_data(tsel_data)
    );

    // {fd_en, brs_en, elem_fdf, elem_brs, err_passive, exp_fdf, exp_brs, exp_esi}
    localparam logic [7:0] VEC [16] = '{
        8'b0000_0_000, 8'b0001_1_001, 8'b0010_1_001, 8'b0011_0_000,
        8'b0100_0_000, 8'b0101_1_001, 8'b0110_1_001, 8'b0111_0_000,
        8'b1000_0_000, 8'b1001_1_001, 8'b1010_1_101, 8'b1011_0_100,
        8'b1100_0_000, 8'b1101_1_001, 8'b1110_1_101, 8'b1111_0_110
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic init, input logic cce, input logic fd, input logic brs);
        cfg_init = init; cfg_cce = cce; cfg_we = 1;
        cfg_fd_en_wr = fd; cfg_brs_en_wr = brs;
        @(negedge clk);
        cfg_we = 0; cfg_init = 0; cfg_cce = 0;
    endtask

    task automatic start_frame(input logic f, input logic b, input logic ep);
        elem_fdf = f; elem_brs = b; err_passive = ep; sof_stb = 1;
        @(negedge clk);
        sof_stb = 0;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: brs_smp_stb = 1;
            1: crc_dlm_stb = 1;
            default: err_stb = 1;
        endcase
        @(negedge clk);
        brs_smp_stb = 0; crc_dlm_stb = 0; err_stb = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1", {2'b0, cfg_fd_en, cfg_brs_en, tx_fdf, tx_brs, tx_esi, tsel_data}, 8'h00);

        // R2: write protection
        wr_cfg(1, 0, 1, 1);
        chk("R2 cce low", {6'b0, cfg_fd_en, cfg_brs_en}, 8'h00);
        wr_cfg(0, 1, 1, 1);
        chk("R2 init low", {6'b0, cfg_fd_en, cfg_brs_en}, 8'h00);
        wr_cfg(1, 1, 1, 0);
        chk("R2 unlocked", {6'b0, cfg_fd_en, cfg_brs_en}, 8'h02);

        // Vector table: R3 R4 R5 R6 R8
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            string tag;
            v = VEC[i];
            wr_cfg(1, 1, v[7], v[6]);
            start_frame(v[5], v[4], v[3]);
            if (!v[7]) tag = "R3";
            else if (!v[5]) tag = "R6";
            else if (!v[6]) tag = "R4";
            else tag = "R5";
            chk(tag, {5'b0, tx_fdf, tx_brs, tx_esi}, {5'b0, v[2:0]});
            chk("R8", {7'b0, tx_esi}, {7'b0, v[3]});
            pulse(1);
        end

        // R7/R8: mid-frame changes do not disturb the frame
        wr_cfg(1, 1, 1, 1);
        start_frame(1, 1, 1);
        elem_fdf = 0; elem_brs = 0; err_passive = 0;
        wr_cfg(1, 1, 0, 0);
        @(negedge clk);
        chk("R7", {6'b0, tx_fdf, tx_brs}, 8'h03);
        chk("R8 hold", {7'b0, tx_esi}, 8'h01);
        pulse(1);

        // R9/R10: switch then back at CRC delimiter
        wr_cfg(1, 1, 1, 1);
        start_frame(1, 1, 0);
        chk("R9 sof nominal", {7'b0, tsel_data}, 8'h00);
        pulse(0);
        chk("R9 data", {7'b0, tsel_data}, 8'h01);
        @(negedge clk);
        chk("R9 data held", {7'b0, tsel_data}, 8'h01);
        pulse(1);
        chk("R10 crc", {7'b0, tsel_data}, 8'h00);
        pulse(0);
        chk("R10 no reentry after crc", {7'b0, tsel_data}, 8'h00);

        // R10: error ends data phase
        start_frame(1, 1, 0);
        pulse(0);
        chk("R9 data again", {7'b0, tsel_data}, 8'h01);
        pulse(2);
        chk("R10 err", {7'b0, tsel_data}, 8'h00);
        pulse(0);
        chk("R10 no reentry after err", {7'b0, tsel_data}, 8'h00);

        // R9: new frame clears data select directly
        start_frame(1, 1, 0);
        pulse(0);
        start_frame(1, 1, 0);
        chk("R9 sof resets", {7'b0, tsel_data}, 8'h00);
        pulse(1);

        // R11: FD frame without switching
        start_frame(1, 0, 0);
        pulse(0);
        chk("R11", {6'b0, tx_brs, tsel_data}, 8'h00);
        pulse(1);

        summary();
    end
endmodule